// File: doc/BRIEF.md
# Requester ID Insertion for a Multi-Function Transmit Stream

This block sits in the outgoing TLP stream of a PCIe endpoint that exposes several physical functions (PFs), each of which may own a group of virtual functions (VFs). Next to the first beat of every packet, the application supplies the PF number, a flag that marks the request as coming from one of that PF's VFs, and the VF's index within its PF. The block turns these into a linear function number and combines it with the bus number held in configuration. It writes the resulting 16-bit requester ID into the packet header and forwards the beat through a single register stage.

Function numbers follow a packed layout that is fixed at elaboration. The PFs come first. After them, each PF's VFs fill one unbroken block, and the blocks are laid out in PF order. The start of each PF's VF block is a prefix sum computed when the design is built, so the work done at run time is one comparison and one add.

Top module: `rid_insert_unit`

## Requirements
- R1: For a start-of-packet beat with the VF flag low, the requester ID is {bus, PF number}. Here bus is the `bus_num` value present when the beat is accepted.
- R2: For a VF request whose index i is below the VF count of PF k, the linear function number is NUM_PF plus the VF counts of PFs 0..k-1 plus i. The stride is 1.
- R3: The ID's low 8 bits are the linear number modulo 256. Its high 8 bits are (bus + linear/256) modulo 256.
- R4: A VF request whose index is greater than or equal to the VF count of its PF raises `out_err` on that output beat. The ID for that beat is then formed as for a PF request (R1).
- R5: When the VF flag is low, the VF index has no effect on the output.
- R6: On a start-of-packet beat, data bits [63:48] (the upper half of header DW1, with DW0 in bits [31:0]) are replaced by the ID. Every other data bit passes through unchanged.
- R7: Beats without start-of-packet pass through with data, sop and eop unchanged and `out_err` low, whatever the PF, VF and flag inputs hold.
- R8: An accepted beat appears on the output one clock after acceptance. `in_ready` is high whenever the output register is empty or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, the output beat holds. No beat is lost, duplicated or reordered.
- R10: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_num | input | 8 | Bus number from configuration |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | DATA_W | Beat data; header DW0 in [31:0], DW1 in [63:32] |
| in_pf | input | 3 | Physical function number |
| in_vf_idx | input | 11 | VF index within the PF |
| in_vf_req | input | 1 | Request comes from a VF of `in_pf` |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_data | output | DATA_W | Beat data with the ID inserted |
| out_err | output | 1 | VF index out of range for this packet |

## Verification
A wrong base in the prefix table, or an off-by-one in the count comparison, shows up as a wrong ID in bits [63:48] of the very next output beat. It can also show up as an `out_err` level that disagrees with the bench's own model, and the scoreboard flags it at that beat. A fault in the handshake register, such as a lost, doubled or changed beat under backpressure, shows up on the next transfer as a mismatch against the front of the expected queue. A beat that goes missing entirely leaves the queue non-empty when the run ends.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int CW = 12;  // wide enough for 8 PFs + 2048 VFs
  localparam int MAXPF = 8;

  // Prefix sum: start of each PF's VF block in the packed function map.
  function automatic logic [MAXPF*CW-1:0] base_table(input logic [MAXPF*CW-1:0] cnt,
                                                     input int npf);
    logic [MAXPF*CW-1:0] t;
    logic [CW-1:0]       run;
    t   = '0;
    run = CW'(npf);
    for (int k = 0; k < MAXPF; k++) begin
      t[k*CW +: CW] = run;
      run = run + cnt[k*CW +: CW];
    end
    return t;
  endfunction

  function automatic logic [CW-1:0] total_vfs(input logic [MAXPF*CW-1:0] cnt);
    logic [CW-1:0] s;
    s = '0;
    for (int k = 0; k < MAXPF; k++) s = s + cnt[k*CW +: CW];
    return s;
  endfunction

  // ARI-style ID: overflow of the linear number above 255 carries into bus.
  function automatic logic [15:0] make_rid(input logic [7:0] bus, input logic [CW-1:0] lin);
    return {bus + 8'(lin >> 8), lin[7:0]};
  endfunction
endpackage

// File: rtl/rid_map.sv
module rid_map
  import rid_pkg::*;
#(
  parameter int NUM_PF = 4,
  parameter logic [MAXPF*CW-1:0] VF_COUNTS = {12'd0, 12'd0, 12'd0, 12'd0,
                                              12'd0, 12'd3, 12'd200, 12'd100}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample,
  input  logic [7:0]  bus,
  input  logic [2:0]  pf,
  input  logic [10:0] vf_idx,
  input  logic        vf_req,
  output logic [15:0] rid,
  output logic        err
);
  localparam logic [MAXPF*CW-1:0] BASES  = base_table(VF_COUNTS, NUM_PF);
  localparam logic [CW-1:0]       NFUNCS = CW'(NUM_PF) + total_vfs(VF_COUNTS);

  logic [CW-1:0] pf_cnt, pf_base, lin;
  logic          vf_use;

  assign pf_cnt  = VF_COUNTS[CW*pf +: CW];
  assign pf_base = BASES[CW*pf +: CW];
  assign vf_use  = vf_req && ({1'b0, vf_idx} < pf_cnt);
  assign lin     = vf_use ? pf_base + {1'b0, vf_idx} : CW'(pf);
  assign err     = vf_req && !vf_use;
  assign rid     = make_rid(bus, lin);

  AST_VF_ABOVE_PFS: assert property (@(posedge clk) disable iff (!rst_n)
    sample && vf_use |-> (lin >= CW'(NUM_PF)) && (lin < NFUNCS)); // R2
  AST_ERR_IS_PF_ID: assert property (@(posedge clk) disable iff (!rst_n)
    sample && err |-> rid[7:0] == {5'd0, pf}); // R4
endmodule

// File: rtl/rid_stage.sv
module rid_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_sop  <= in_sop;
      out_eop  <= in_eop;
      out_data <= in_data;
      out_err  <= in_err;
    end
  end

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8
endmodule

// File: rtl/rid_insert_unit.sv
module rid_insert_unit
  import rid_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int NUM_PF = 4,
  parameter logic [MAXPF*CW-1:0] VF_COUNTS = {12'd0, 12'd0, 12'd0, 12'd0,
                                              12'd0, 12'd3, 12'd200, 12'd100}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_num,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        in_pf,
  input  logic [10:0]       in_vf_idx,
  input  logic              in_vf_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  localparam int RID_LSB = 48;  // upper half of header DW1

  logic [15:0]       rid;
  logic              map_err, hdr_beat;
  logic [DATA_W-1:0] patched;

  assign hdr_beat = in_valid && in_sop;

  rid_map #(.NUM_PF(NUM_PF), .VF_COUNTS(VF_COUNTS)) u_map (
    .clk(clk), .rst_n(rst_n), .sample(hdr_beat), .bus(bus_num),
    .pf(in_pf), .vf_idx(in_vf_idx), .vf_req(in_vf_req),
    .rid(rid), .err(map_err)
  );

  always_comb begin
    patched = in_data;
    if (in_sop) patched[RID_LSB +: 16] = rid;
  end

  rid_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(patched), .in_err(in_sop && map_err),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .out_err(out_err)
  );

  AST_ERR_ON_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_sop); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                && $stable(out_eop) && $stable(out_err)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R10
endmodule

// File: tb/rid_insert_unit_bench.sv
module rid_insert_unit_bench;
  localparam int DW = 128;
  localparam int NPF = 4;
  int cnt_tab [4] = '{100, 200, 3, 0};

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_num = 8'h3A;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_vf_req = 0, out_ready = 1;
  logic [DW-1:0] in_data = '0;
  logic [2:0] in_pf = 0;
  logic [10:0] in_vf_idx = 0;
  logic in_ready, out_valid, out_sop, out_eop, out_err;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  bit stress = 0;
  logic [DW+2:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  rid_insert_unit u_rid_insert_unit (
    .clk(clk), .rst_n(rst_n), .bus_num(bus_num),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_pf(in_pf), .in_vf_idx(in_vf_idx), .in_vf_req(in_vf_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .out_err(out_err)
  );

  task automatic check(input bit ok, input string tag, input logic [DW+2:0] act,
                       input logic [DW+2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: walk the PFs to find the VF block start.
  function automatic logic [15:0] model_rid(input logic [7:0] bus, input int pf,
                                            input int idx, input bit vfr, output bit err);
    int lin, start;
    start = NPF;
    for (int j = 0; j < pf && j < 4; j++) start += cnt_tab[j];
    err = 0;
    lin = pf;
    if (vfr) begin
      if (pf < 4 && idx < cnt_tab[pf]) lin = start + idx;
      else err = 1;
    end
    return {8'((int'(bus) + lin / 256) % 256), 8'(lin % 256)};
  endfunction

  task automatic send_beat(input bit sop, input bit eop, input logic [DW-1:0] d,
                           input int pf, input int idx, input bit vfr, input string tag);
    logic [DW-1:0] ed;
    bit e;
    logic [15:0] r;
    r  = model_rid(bus_num, pf, idx, vfr, e);
    ed = d;
    if (sop) ed[63:48] = r;
    else e = 0;
    @(negedge clk); #2;
    in_valid = 1; in_sop = sop; in_eop = eop; in_data = d;
    in_pf = 3'(pf); in_vf_idx = 11'(idx); in_vf_req = vfr;
    forever begin
      #5;
      if (in_ready) break;
      @(negedge clk); #2;
    end
    exp_q.push_back({sop, eop, e, ed});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    // R8: visible one clock after acceptance
    check(out_valid === 1'b1 && out_data === ed, "R8",
          {out_sop, out_eop, out_err, out_data}, {sop, eop, e, ed});
    in_valid = 0;
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stress ? (($urandom % 4) != 0) : 1'b1;
      #5;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 dup", {out_sop, out_eop, out_err, out_data}, '0);
        end else begin
          logic [DW+2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_sop, out_eop, out_err, out_data} === e, t,
                {out_sop, out_eop, out_err, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(out_valid === 1'b0, "R10", {2'b0, out_valid, {DW{1'b0}}}, '0);
    @(negedge clk); rst_n = 1;
    #5 check(in_ready === 1'b1, "R8 idle ready", {2'b0, in_ready, {DW{1'b0}}}, {3'b001, {DW{1'b0}}});

    for (int p = 0; p < 4; p++) send_beat(1, 1, rnd_data(), p, 7, 0, "R1");
    send_beat(1, 1, rnd_data(), 0, 0, 1, "R2 pf0 first");
    send_beat(1, 1, rnd_data(), 0, 99, 1, "R2 pf0 last");
    send_beat(1, 1, rnd_data(), 1, 0, 1, "R2 pf1 first");
    send_beat(1, 1, rnd_data(), 1, 151, 1, "R2 lin255");
    send_beat(1, 1, rnd_data(), 1, 152, 1, "R3 lin256");
    send_beat(1, 1, rnd_data(), 1, 199, 1, "R3 pf1 last");
    send_beat(1, 1, rnd_data(), 2, 2, 1, "R3 pf2 last");
    send_beat(1, 1, rnd_data(), 0, 100, 1, "R4 pf0 over");
    send_beat(1, 1, rnd_data(), 2, 3, 1, "R4 pf2 over");
    send_beat(1, 1, rnd_data(), 3, 0, 1, "R4 pf3 none");
    send_beat(1, 1, rnd_data(), 1, 50, 0, "R5 flag low");
    send_beat(1, 1, rnd_data(), 2, 2047, 0, "R5 flag low big idx");
    send_beat(1, 0, rnd_data(), 1, 10, 1, "R6 header");
    for (int b = 0; b < 3; b++)
      send_beat(0, b == 2, rnd_data(), $urandom % 4, $urandom % 300, 1, "R7 body");
    @(negedge clk); bus_num = 8'hFF;
    send_beat(1, 1, rnd_data(), 1, 152, 1, "R3 bus wrap");
    send_beat(1, 1, rnd_data(), 3, 0, 0, "R1 bus FF");
    @(negedge clk); bus_num = 8'h07;

    stress = 1;
    for (int n = 0; n < 200; n++) begin
      int len;
      len = 1 + $urandom % 3;
      for (int b = 0; b < len; b++)
        send_beat(b == 0, b == len - 1, rnd_data(), $urandom % 4, $urandom % 210,
                  $urandom % 2, b == 0 ? "R9 stress hdr" : "R9 stress body");
    end
    stress = 0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 drained", (DW+3)'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule